// File: doc/BRIEF.md
# ADC Output Format Converter

This block sits between a 10-bit converter core and its output pins. Each incoming sample is in offset-binary form. The block first adds a signed correction of whole LSBs to the sample, then recodes the result into the number format chosen by a 2-bit select. It can then complement every bit. The result is captured in an output register one clock after the sample arrives.

The controls are sampled in the same cycle as the sample they apply to. A disable input blanks the output register: the data goes to all zeros and the valid flag stays low for as long as the input is held. In a cycle with no valid sample the output register keeps its last data word and drops its valid flag.

Top module: `adc_fmt_conv`

## Requirements
- R1: While reset is asserted, and after it is released until the first captured sample, `dataOut` is 0 and `dataValid` is 0.
- R2: The signed 8-bit two's complement `trimIn` (range -128..+127) is added to the sample. The sum saturates at 0 and at 1023 and does not wrap.
- R3: With `fmtSel` 2'b00 or 2'b11 the output is the trimmed value in offset binary, unchanged.
- R4: With `fmtSel` 2'b01 the output is the trimmed value with bit 9 inverted, which gives two's complement.
- R5: With `fmtSel` 2'b10 the output is Gray code: the trimmed value XOR the trimmed value shifted right by one bit.
- R6: When `invertEn` is 1, all 10 bits of the formatted word are complemented. This step comes after the format conversion.
- R7: When `outDisable` is 1 at a rising edge, `dataOut` becomes all zeros and `dataValid` becomes 0 after that edge, whatever `sampleValid` is.
- R8: A sample with `sampleValid` 1 and `outDisable` 0 at a rising edge appears on `dataOut`, with `dataValid` 1, right after that same edge. If `sampleValid` is 0 at an edge, `dataValid` is 0 after it.
- R9: At an edge where `sampleValid` is 0 and `outDisable` is 0, `dataOut` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | 10 | Offset-binary converter sample |
| sampleValid | input | 1 | Sample qualifier |
| trimIn | input | 8 | Signed offset correction in LSBs |
| fmtSel | input | 2 | Output format: 00/11 offset binary, 01 two's complement, 10 Gray |
| invertEn | input | 1 | Complement all output bits |
| outDisable | input | 1 | Blank the output register |
| dataOut | output | 10 | Formatted sample |
| dataValid | output | 1 | Qualifies dataOut |

## Verification
The bench runs the main path with the following stimulus:
- Directed samples at midscale, at the ends of the range and on single-bit patterns. With the trim at zero, these show the three format encodings apart: only bit 9 separates two's complement from offset binary, and Gray differs in many lower bits.
- Trims of +127 and -128 at the range ends. These show saturation apart from wraparound.
- Inverted words in each format. These confirm that the complement comes after recoding and not before it.
- A long pseudo-random run that mixes all controls with idle and disabled cycles. It exercises the hold and blanking paths against the bench's own model.

// File: rtl/fmtconv_pkg.sv
package fmtconv_pkg;

  typedef enum logic [1:0] {
    FMT_OFFBIN     = 2'b00,
    FMT_TWOS       = 2'b01,
    FMT_GRAY       = 2'b10,
    FMT_OFFBIN_ALT = 2'b11
  } fmt_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic capture;  // load a new formatted word
    logic blank;    // force register to zero
    logic flipAll;  // complement whole word
    logic flipMsb;  // two's complement recoding
    logic grayEn;   // Gray recoding
  } dp_ctrl_t;

endpackage

// File: rtl/fmt_ctrl.sv
module fmt_ctrl
  import fmtconv_pkg::*;
(
  input  logic      sampleValid,
  input  logic [1:0] fmtSel,
  input  logic      invertEn,
  input  logic      outDisable,
  output dp_ctrl_t  ctrl
);

  fmt_e fmtMode;

  always_comb begin
    fmtMode      = fmt_e'(fmtSel);
    ctrl         = '0;
    ctrl.blank   = outDisable;
    ctrl.capture = sampleValid & ~outDisable;
    ctrl.flipAll = invertEn;
    unique case (fmtMode)
      FMT_TWOS: ctrl.flipMsb = 1'b1;
      FMT_GRAY: ctrl.grayEn  = 1'b1;
      default:  begin
        ctrl.flipMsb = 1'b0;
        ctrl.grayEn  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/fmt_datapath.sv
module fmt_datapath
  import fmtconv_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int TRIM_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [TRIM_W-1:0]   trimIn,
  input  dp_ctrl_t            ctrl,
  output logic [SAMPLE_W-1:0] dataOut,
  output logic                dataValid
);

  localparam int WIDE_W = ((SAMPLE_W > TRIM_W) ? SAMPLE_W : TRIM_W) + 2;
  localparam logic [WIDE_W-1:0] MAX_CODE = WIDE_W'((1 << SAMPLE_W) - 1);

  logic [WIDE_W-1:0]   sampleWide;
  logic [WIDE_W-1:0]   trimWide;
  logic [WIDE_W-1:0]   sumWide;
  logic                sumNeg;
  logic                sumOver;
  logic [SAMPLE_W-1:0] trimmed;
  logic [SAMPLE_W-1:0] grayVal;
  logic [SAMPLE_W-1:0] formatted;
  logic [SAMPLE_W-1:0] finalWord;

  // saturating offset trim
  always_comb begin
    sampleWide = {{(WIDE_W-SAMPLE_W){1'b0}}, sampleIn};
    trimWide   = {{(WIDE_W-TRIM_W){trimIn[TRIM_W-1]}}, trimIn};
    sumWide    = sampleWide + trimWide;
    sumNeg     = sumWide[WIDE_W-1];
    sumOver    = ~sumNeg && (sumWide > MAX_CODE);
    if (sumNeg)       trimmed = '0;
    else if (sumOver) trimmed = MAX_CODE[SAMPLE_W-1:0];
    else              trimmed = sumWide[SAMPLE_W-1:0];
  end

  // Gray recoding, one XOR per bit below the MSB
  assign grayVal[SAMPLE_W-1] = trimmed[SAMPLE_W-1];
  for (genvar b = 0; b < SAMPLE_W-1; b++) begin : g_gray
    assign grayVal[b] = trimmed[b] ^ trimmed[b+1];
  end

  always_comb begin
    if (ctrl.grayEn)       formatted = grayVal;
    else if (ctrl.flipMsb) formatted = {~trimmed[SAMPLE_W-1], trimmed[SAMPLE_W-2:0]};
    else                   formatted = trimmed;
    finalWord = ctrl.flipAll ? ~formatted : formatted;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else if (ctrl.blank) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= ctrl.capture;
      if (ctrl.capture) dataOut <= finalWord;
    end
  end

endmodule

// File: rtl/adc_fmt_conv.sv
module adc_fmt_conv
  import fmtconv_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int TRIM_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic [TRIM_W-1:0]   trimIn,
  input  logic [1:0]          fmtSel,
  input  logic                invertEn,
  input  logic                outDisable,
  output logic [SAMPLE_W-1:0] dataOut,
  output logic                dataValid
);

  dp_ctrl_t ctrlBus;

  fmt_ctrl u_ctrl (
    .sampleValid (sampleValid),
    .fmtSel      (fmtSel),
    .invertEn    (invertEn),
    .outDisable  (outDisable),
    .ctrl        (ctrlBus)
  );

  fmt_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .TRIM_W   (TRIM_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sampleIn  (sampleIn),
    .trimIn    (trimIn),
    .ctrl      (ctrlBus),
    .dataOut   (dataOut),
    .dataValid (dataValid)
  );

endmodule

// File: rtl/fmt_checker.sv
module fmt_checker #(
  parameter int SAMPLE_W = 10,
  parameter int TRIM_W   = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [SAMPLE_W-1:0] sampleIn,
  input logic                sampleValid,
  input logic [TRIM_W-1:0]   trimIn,
  input logic [1:0]          fmtSel,
  input logic                invertEn,
  input logic                outDisable,
  input logic [SAMPLE_W-1:0] dataOut,
  input logic                dataValid
);

  // R7: blanking
  p_blank_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    outDisable |=> (dataOut == '0) && !dataValid);

  // R8: one-cycle latency of the valid flag
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !outDisable) |=> dataValid);

  p_idle_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !dataValid);

  // R9: hold on idle cycles
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && !outDisable) |=> $stable(dataOut));

  // R5: Gray output with no trim and no inversion
  p_gray_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !outDisable && fmtSel == 2'b10 && !invertEn && trimIn == '0)
    |=> dataOut == ($past(sampleIn) ^ ($past(sampleIn) >> 1)));

  // R4: two's complement differs from the sample only in the MSB
  p_twos_msb_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !outDisable && fmtSel == 2'b01 && !invertEn && trimIn == '0)
    |=> dataOut == {~$past(sampleIn[SAMPLE_W-1]), $past(sampleIn[SAMPLE_W-2:0])});

endmodule

bind adc_fmt_conv fmt_checker #(
  .SAMPLE_W (SAMPLE_W),
  .TRIM_W   (TRIM_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleIn    (sampleIn),
  .sampleValid (sampleValid),
  .trimIn      (trimIn),
  .fmtSel      (fmtSel),
  .invertEn    (invertEn),
  .outDisable  (outDisable),
  .dataOut     (dataOut),
  .dataValid   (dataValid)
);

// File: tb/sim_adc_fmt_conv.sv
`timescale 1ns/1ps
module sim_adc_fmt_conv;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] sampleIn = '0;
  logic       sampleValid = 1'b0;
  logic [7:0] trimIn = '0;
  logic [1:0] fmtSel = '0;
  logic       invertEn = 1'b0;
  logic       outDisable = 1'b0;
  logic [9:0] dataOut;
  logic       dataValid;

  always #2 clk = ~clk;

  adc_fmt_conv u0 (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .trimIn(trimIn), .fmtSel(fmtSel), .invertEn(invertEn),
    .outDisable(outDisable), .dataOut(dataOut), .dataValid(dataValid)
  );

  typedef struct {
    logic [9:0] data;
    logic       valid;
    string      req;
  } exp_t;

  exp_t expQ[$];
  int   errors = 0;
  int   checks = 0;
  logic [9:0] modelHold = '0;
  bit   done = 0;

  function automatic logic [9:0] model(input logic [9:0] s, input logic [7:0] t,
                                       input logic [1:0] f, input logic inv);
    int sum;
    logic [9:0] v, o;
    sum = int'(s) + int'($signed(t));
    if (sum < 0) sum = 0;
    if (sum > 1023) sum = 1023;
    v = sum[9:0];
    case (f)
      2'b01:   o = v ^ 10'h200;
      2'b10:   o = v ^ {1'b0, v[9:1]};
      default: o = v;
    endcase
    return inv ? ~o : o;
  endfunction

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp_v);
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp_v);
    end
  endtask

  task automatic drive(input logic [9:0] s, input logic [7:0] t, input logic [1:0] f,
                       input logic inv, input logic dis, input logic vld, input string req);
    exp_t e;
    @(negedge clk);
    sampleIn = s; trimIn = t; fmtSel = f; invertEn = inv;
    outDisable = dis; sampleValid = vld;
    if (dis) modelHold = '0;
    else if (vld) modelHold = model(s, t, f, inv);
    e.data = modelHold;
    e.valid = vld && !dis;
    e.req = req;
    expQ.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check({e.req, " data"}, dataOut, e.data);
        check({e.req, " valid"}, {9'b0, dataValid}, {9'b0, e.valid});
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset data", dataOut, 10'h000);
    check("R1 reset valid", {9'b0, dataValid}, 10'h000);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", dataOut, 10'h000);

    // R3 offset binary, both codes
    drive(10'h200, 8'h00, 2'b00, 0, 0, 1, "R3 midscale");
    drive(10'h155, 8'h00, 2'b11, 0, 0, 1, "R3 alt code");
    drive(10'h3FF, 8'h00, 2'b00, 0, 0, 1, "R3 full");
    // R2 trim and saturation
    drive(10'h100, 8'h05, 2'b00, 0, 0, 1, "R2 plus trim");
    drive(10'h100, 8'hFB, 2'b00, 0, 0, 1, "R2 minus trim");
    drive(10'h005, 8'h80, 2'b00, 0, 0, 1, "R2 sat low");
    drive(10'h3E8, 8'h7F, 2'b00, 0, 0, 1, "R2 sat high");
    drive(10'h380, 8'h7F, 2'b00, 0, 0, 1, "R2 no sat");
    // R4 two's complement
    drive(10'h000, 8'h00, 2'b01, 0, 0, 1, "R4 zero");
    drive(10'h3FF, 8'h00, 2'b01, 0, 0, 1, "R4 full");
    drive(10'h1FF, 8'h01, 2'b01, 0, 0, 1, "R4 with trim");
    // R5 Gray
    drive(10'h2AA, 8'h00, 2'b10, 0, 0, 1, "R5 pattern");
    drive(10'h200, 8'h00, 2'b10, 0, 0, 1, "R5 msb");
    drive(10'h3FF, 8'h00, 2'b10, 0, 0, 1, "R5 ones");
    // R6 inversion after format
    drive(10'h2AA, 8'h00, 2'b10, 1, 0, 1, "R6 gray inv");
    drive(10'h123, 8'h00, 2'b01, 1, 0, 1, "R6 twos inv");
    drive(10'h000, 8'h00, 2'b00, 1, 0, 1, "R6 ob inv");
    // R9 hold, R8 valid low
    drive(10'h111, 8'h00, 2'b00, 0, 0, 0, "R9 idle hold");
    drive(10'h222, 8'h10, 2'b01, 1, 0, 0, "R8 idle valid");
    // R7 disable overrides valid
    drive(10'h3FF, 8'h00, 2'b00, 1, 1, 1, "R7 blank");
    drive(10'h0F0, 8'h00, 2'b00, 0, 1, 0, "R7 blank idle");
    drive(10'h0F0, 8'h00, 2'b00, 0, 0, 1, "R8 resume");

    // mixed pseudo-random run
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[9:0], r[17:10], r[19:18], r[20], (r[23:21] == 3'd0),
            (r[25:24] != 2'd0), "R2 random");
    end
    drive(10'h000, 8'h00, 2'b00, 0, 0, 0, "R8 drain");
    repeat (3) @(posedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule